// File: doc/BRIEF.md
# Parallel Configuration Memory Address Sequencer

This block fetches a configuration image from an external byte-wide memory while the device loads itself as the master of that load. A start pulse launches a load. The block drives a 16-bit address, waits a fixed number of clocks for the memory access time, captures the returned byte, and shifts it out serially to the configuration logic. Then it moves on to the next address. The load stops after the byte at a final address, which is captured when the load starts.

Before every address change, a dedicated strobe output rises for one clock, so external logic can follow the progress of the load. The two lowest address bits are also copied to two alternate outputs. A hold-off input stops a load from starting. During a load, the hold-off input freezes the sequencer exactly where it is until the input is released.

Top module: `cfg_addr_seq`

## Requirements
- R1: After reset, the address is 0, and the strobe, serial valid, busy and done outputs are all low.
- R2: A start pulse sampled while hold-off is low makes the strobe and busy outputs high in the next cycle. In the cycle after that, the address becomes 0.
- R3: The address changes only in the cycle after the strobe was high. After the first update to 0, each update adds exactly 1 to the address.
- R4: The memory byte is captured ACCESS_CYC clock edges after the address update. The first serial bit is valid ACCESS_CYC cycles after the new address appears.
- R5: Each captured byte is sent on the serial output over 8 consecutive valid cycles, most significant bit first. The next strobe follows directly after the eighth bit.
- R6: After the eighth bit of the byte at the captured final address, done goes high and stays high, and busy goes low. The strobe stays low and the address holds. With no hold-off, a load with final address L ends (L+1)·(ACCESS_CYC+9)+1 cycles after the start cycle.
- R7: The two alternate outputs always equal address bits 0 and 1.
- R8: While hold-off is high during a load, the address, strobe and busy state keep their values, serial valid is low, and no progress is made. When hold-off is released, the load resumes without losing or repeating any bit.
- R9: A start pulse given while hold-off is high is ignored.
- R10: A start pulse given during a load is ignored, and the byte stream of that load is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a load (single-cycle pulse) |
| hold_i | input | 1 | Hold-off: blocks start, freezes a running load |
| last_addr_i | input | 16 | Final address of the load, captured at start |
| mem_data_i | input | 8 | Byte returned by the external memory |
| mem_addr_o | output | 16 | Address to the external memory |
| addr_strobe_o | output | 1 | High for one cycle before each address change |
| alt_a0_o | output | 1 | Copy of address bit 0 |
| alt_a1_o | output | 1 | Copy of address bit 1 |
| ser_data_o | output | 1 | Serial configuration bit, MSB first |
| ser_valid_o | output | 1 | ser_data_o carries a bit this cycle |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | The last load has completed |

## Verification
Outputs are sampled on the falling edge. Each result is expected in a fixed cycle counted from the start pulse: the strobe one cycle after start, the address one cycle after the strobe, the first serial bit ACCESS_CYC cycles after the address update, the next strobe one cycle after the eighth bit, and done (L+1)·(ACCESS_CYC+9)+1 cycles after start. The memory model returns the inverted byte until the address has been stable for ACCESS_CYC-1 sampled cycles, so capturing the byte one cycle early produces a wrong byte. Runs that use hold-off drop the absolute cycle counts. They instead check that nothing moves during hold-off and that the byte stream comes out intact.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_STROBE = 3'd1,
    ST_WAIT   = 3'd2,
    ST_SHIFT  = 3'd3,
    ST_DONE   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/seq_addr_reg.sv
module seq_addr_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              cap_last_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              is_last_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (clr_i) begin
      addr_q <= '0;
    end else if (step_i) begin
      addr_q <= addr_q + ADDR_W'(1);
    end
  end

  // final address captured at start; later changes on the input are ignored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
    end else if (cap_last_i) begin
      last_q <= last_i;
    end
  end

  assign addr_o    = addr_q;
  assign is_last_o = (addr_q == last_q);
endmodule

// File: rtl/seq_access_timer.sv
module seq_access_timer #(
  parameter int ACCESS_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic expired_o
);
  generate
    if (ACCESS_CYC <= 1) begin : g_single
      // capture on the first edge after the update: nothing to count
      assign expired_o = 1'b1;
    end else begin : g_count
      localparam int CNT_W = $clog2(ACCESS_CYC);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (load_i) begin
          cnt_q <= CNT_W'(ACCESS_CYC - 1);
        end else if (dec_i && cnt_q != '0) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end

      assign expired_o = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/seq_byte_shifter.sv
module seq_byte_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o,
  output logic              last_bit_o
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sreg_q;
  logic [BIT_W-1:0]  bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      bit_q  <= '0;
    end else if (load_i) begin
      sreg_q <= data_i;
      bit_q  <= '0;
    end else if (shift_i) begin
      sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
      bit_q  <= bit_q + BIT_W'(1);
    end
  end

  assign bit_o      = sreg_q[DATA_W-1];
  assign last_bit_o = (bit_q == BIT_W'(DATA_W - 1));
endmodule

// File: rtl/cfg_addr_seq.sv
module cfg_addr_seq
  import cfg_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int ACCESS_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              hold_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              addr_strobe_o,
  output logic              alt_a0_o,
  output logic              alt_a1_o,
  output logic              ser_data_o,
  output logic              ser_valid_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e state_q, state_d;
  logic       first_q, first_d;

  logic adv;
  logic go;
  logic addr_clr, addr_step, is_last;
  logic tmr_load, tmr_dec, tmr_exp;
  logic sh_load, sh_shift, sh_last;

  assign adv = !hold_i;
  assign go  = start_i && !hold_i && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    state_d   = state_q;
    first_d   = first_q;
    addr_clr  = 1'b0;
    addr_step = 1'b0;
    tmr_load  = 1'b0;
    tmr_dec   = 1'b0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (go) begin
          state_d = ST_STROBE;
          first_d = 1'b1;
        end
      end
      ST_STROBE: begin
        if (adv) begin
          state_d   = ST_WAIT;
          first_d   = 1'b0;
          addr_clr  = first_q;
          addr_step = !first_q;
          tmr_load  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (adv) begin
          if (tmr_exp) begin
            sh_load = 1'b1;
            state_d = ST_SHIFT;
          end else begin
            tmr_dec = 1'b1;
          end
        end
      end
      ST_SHIFT: begin
        if (adv) begin
          if (sh_last) begin
            state_d = is_last ? ST_DONE : ST_STROBE;
          end else begin
            sh_shift = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
    end
  end

  seq_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (addr_clr),
    .step_i     (addr_step),
    .cap_last_i (go),
    .last_i     (last_addr_i),
    .addr_o     (mem_addr_o),
    .is_last_o  (is_last)
  );

  seq_access_timer #(.ACCESS_CYC(ACCESS_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .dec_i     (tmr_dec),
    .expired_o (tmr_exp)
  );

  seq_byte_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sh_load),
    .shift_i    (sh_shift),
    .data_i     (mem_data_i),
    .bit_o      (ser_data_o),
    .last_bit_o (sh_last)
  );

  assign addr_strobe_o = (state_q == ST_STROBE);
  assign ser_valid_o   = (state_q == ST_SHIFT) && adv;
  assign busy_o        = (state_q == ST_STROBE) || (state_q == ST_WAIT) || (state_q == ST_SHIFT);
  assign done_o        = (state_q == ST_DONE);
  assign alt_a0_o      = mem_addr_o[0];
  assign alt_a1_o      = mem_addr_o[1];
endmodule

// File: rtl/cfg_addr_seq_chk.sv
module cfg_addr_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hold_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              addr_strobe_o,
  input logic              alt_a0_o,
  input logic              alt_a1_o,
  input logic              ser_valid_o,
  input logic              busy_o,
  input logic              done_o
);
  a_r3_change_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_addr_o != $past(mem_addr_o)) |-> $past(addr_strobe_o));

  a_r3_step_or_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_addr_o != $past(mem_addr_o)) |->
      (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1) || mem_addr_o == '0));

  a_r5_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_strobe_o && !hold_i) |=> !addr_strobe_o);

  a_r6_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!addr_strobe_o && !busy_o));

  a_r7_alt_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_a0_o == mem_addr_o[0]) && (alt_a1_o == mem_addr_o[1]));

  a_r8_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && busy_o) |=> $stable(mem_addr_o));

  a_r8_hold_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && busy_o) |=> ($stable(addr_strobe_o) && busy_o));

  a_r8_hold_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !ser_valid_o);
endmodule

bind cfg_addr_seq cfg_addr_seq_chk #(.ADDR_W(ADDR_W)) u_cfg_addr_seq_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hold_i        (hold_i),
  .mem_addr_o    (mem_addr_o),
  .addr_strobe_o (addr_strobe_o),
  .alt_a0_o      (alt_a0_o),
  .alt_a1_o      (alt_a1_o),
  .ser_valid_o   (ser_valid_o),
  .busy_o        (busy_o),
  .done_o        (done_o)
);

// File: tb/cfg_addr_seq_tb_top.sv
`timescale 1ns/1ps
module cfg_addr_seq_tb_top;
  localparam int AW       = 16;
  localparam int DW       = 8;
  localparam int ACC      = 3;
  localparam int BYTE_CYC = 1 + ACC + DW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          hold_i = 1'b0;
  logic [AW-1:0] last_addr_i = '0;
  logic [DW-1:0] mem_data_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic          addr_strobe_o, alt_a0_o, alt_a1_o;
  logic          ser_data_o, ser_valid_o, busy_o, done_o;

  always #2.5 clk_i = ~clk_i;

  cfg_addr_seq #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CYC(ACC)) dut_i (
    .clk_i, .rst_ni, .start_i, .hold_i, .last_addr_i, .mem_data_i,
    .mem_addr_o, .addr_strobe_o, .alt_a0_o, .alt_a1_o,
    .ser_data_o, .ser_valid_o, .busy_o, .done_o
  );

  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor state
  bit            mon_en = 0, run_fin = 0;
  int            cyc, hold_at, hold_len, start_at;
  logic [AW-1:0] last_cfg, prev_addr, exp_addr, age;
  logic          prev_strobe, prev_valid, prev_busy, prev_done, hp;
  int            upd_cyc, bit_n, nbytes;
  logic [DW-1:0] bit_acc;

  always @(negedge clk_i) begin
    if (mon_en) begin
      hp = hold_i;
      if (cyc == 0) begin
        prev_addr = mem_addr_o; prev_strobe = addr_strobe_o; prev_valid = 1'b0;
        prev_busy = busy_o; prev_done = done_o; exp_addr = '0;
        bit_n = 0; nbytes = 0; upd_cyc = 0; age = '0;
      end
      if (cyc == 1) begin
        chk("R2", "strobe after start", addr_strobe_o, 1);
        chk("R2", "busy after start", busy_o, 1);
        chk("R2", "done cleared", done_o, 0);
      end
      chk("R7", "alt a0", alt_a0_o, mem_addr_o[0]);
      chk("R7", "alt a1", alt_a1_o, mem_addr_o[1]);
      if (hp) begin
        chk("R8", "valid during hold", ser_valid_o, 0);
        if (prev_busy) begin
          chk("R8", "addr frozen", mem_addr_o, prev_addr);
          chk("R8", "strobe frozen", addr_strobe_o, prev_strobe);
        end
      end
      if (cyc > 0 && mem_addr_o != prev_addr) chk("R3", "strobe before change", prev_strobe, 1);
      if (cyc > 0 && prev_strobe && !hp) begin
        chk("R3", "address update", mem_addr_o, exp_addr);
        if (exp_addr == '0) chk("R2", "first address zero", mem_addr_o, 0);
        exp_addr = mem_addr_o + AW'(1);
        upd_cyc = cyc; age = '0; bit_n = 0;
      end
      if (ser_valid_o) begin
        if (bit_n == 0 && hold_len == 0) chk("R4", "first bit delay", cyc - upd_cyc, ACC);
        bit_acc = {bit_acc[DW-2:0], ser_data_o};
        bit_n++;
        if (bit_n == DW) begin
          chk("R5", "serial byte", bit_acc, mem_f(mem_addr_o));
          nbytes++; bit_n = 0;
        end
      end
      if (addr_strobe_o && !prev_strobe && nbytes > 0 && hold_len == 0)
        chk("R5", "strobe follows last bit", prev_valid, 1);
      if (cyc > 0 && done_o && !prev_done) begin
        chk("R6", "final address", mem_addr_o, last_cfg);
        chk("R6", "byte count", nbytes, int'(last_cfg) + 1);
        chk("R6", "busy low at done", busy_o, 0);
        chk("R6", "strobe low at done", addr_strobe_o, 0);
        if (hold_len == 0) chk("R6", "done cycle", cyc, 1 + (int'(last_cfg) + 1) * BYTE_CYC);
        mon_en = 0; run_fin = 1;
      end
      prev_addr = mem_addr_o; prev_strobe = addr_strobe_o; prev_valid = ser_valid_o;
      prev_busy = busy_o; prev_done = done_o;
      if (mon_en) begin
        start_i = (cyc == 0) || (cyc == start_at);
        hold_i  = (hold_len > 0) && (cyc >= hold_at) && (cyc < hold_at + hold_len);
      end else begin
        start_i = 1'b0; hold_i = 1'b0;
      end
      mem_data_i = (age >= AW'(ACC - 1)) ? mem_f(mem_addr_o) : ~mem_f(mem_addr_o);
      if (age != '1) age = age + AW'(1);
      cyc++;
    end
  end

  task automatic run_load(input int last, input int hat, input int hlen, input int sat);
    last_cfg = AW'(last); last_addr_i = AW'(last);
    hold_at = hat; hold_len = hlen; start_at = sat;
    cyc = 0; run_fin = 0;
    @(posedge clk_i);
    mon_en = 1;
    for (int i = 0; i < 20000 && !run_fin; i++) @(posedge clk_i);
    if (!run_fin) begin
      mon_en = 0;
      chk("R6", "load never completed", 0, 1);
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R6", "done holds", done_o, 1);
      chk("R6", "address holds", mem_addr_o, AW'(last));
      chk("R6", "strobe stays low", addr_strobe_o, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    chk("R1", "reset addr", mem_addr_o, 0);
    chk("R1", "reset strobe", addr_strobe_o, 0);
    chk("R1", "reset valid", ser_valid_o, 0);
    chk("R1", "reset busy", busy_o, 0);
    chk("R1", "reset done", done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9: start blocked by hold-off while idle
    hold_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R9", "busy with hold", busy_o, 0);
    chk("R9", "strobe with hold", addr_strobe_o, 0);
    hold_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R9", "still idle", busy_o, 0);
    chk("R9", "address untouched", mem_addr_o, 0);

    for (int l = 0; l < 10; l++) run_load(l, 0, 0, -1);
    for (int h = 1; h < 15; h++) run_load(2, h, 4, -1);
    run_load(5, 20, 1, -1);
    run_load(40, 30, 7, 100);      // R10: restart pulse ignored mid-load
    run_load(300, 0, 0, 500);      // R10 without hold, exact timing kept

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule